// File: doc/BRIEF.md
# Dual-Predicated Element Index Sequencer

This block turns one vectorised scalar load or store into a series of per-element operation descriptors. A single-cycle start pulse carries the vector length, the source and destination register numbers, the immediate offset, two predicate masks and a mode bit. Both register numbers are first passed through a 32-entry redirection table. Each entry can replace a register number with a stored target and can mark the register as a vector. The block then walks two element indices. The source index skips lanes whose source mask bit is clear, and the destination index skips lanes whose destination mask bit is clear. Each issued descriptor names the effective source register (the base address for the access), the effective destination register and the immediate.

Descriptors leave on a valid/ready handshake. When the walk is over, a one-cycle done pulse is raised. In shared-mask mode, the source mask gates both sides through a single lane index. A scalar side never moves its index, so a walk with both sides scalar issues exactly one descriptor. Address arithmetic, register file access and memory access are handled downstream.

Top module: `elem_seq_top`

## Requirements
- R1: On start, each register number is looked up in the redirection table, using the entry at the register's own number. If that entry is active, its 5-bit target replaces the number; otherwise the number passes through unchanged. A side is a vector only when its entry is active and has the vector flag set. An inactive entry makes that side scalar.
- R2: In dual-mask mode, mask bit n belongs to lane n. Before issuing, a vector source index skips every lane whose source mask bit is 0. A vector destination index does the same using the destination mask. Descriptors come out in increasing lane order.
- R3: Each descriptor carries op_rs = effective source + i and op_rd = effective destination + j, modulo 32. The offset is 0 for a scalar side. After each accepted descriptor, i increments only if the source is a vector, and j increments only if the destination is a vector.
- R4: The walk ends as soon as i reaches the vector length, or (in dual-mask mode) j reaches it. No descriptor is issued for a lane at or beyond that length, even when a skip runs off the end. Done is then high for exactly one cycle.
- R5: In dual-mask mode with both sides scalar, exactly one descriptor is issued, and then done follows.
- R6: In shared-mask mode (start_shared=1), a single lane index walks the source mask and skips lanes whose bit is 0. The source offset is that lane if the source is a vector, and the destination offset is that lane if the destination is a vector. A scalar destination ends the walk after its first accepted descriptor.
- R7: A vector length of 0 issues nothing, and done is high in the cycle after the start pulse. A length above 8 is treated as 8.
- R8: While op_valid is high and op_ready is low, op_valid stays high and op_rs, op_rd and op_imm hold their values. A descriptor counts as issued only in a cycle where valid and ready are both high.
- R9: Each index moves by at most one lane per clock. With only lane 7 enabled on a vector source, the first descriptor appears 8 cycles after start.
- R10: A start pulse that arrives while a walk is in progress, including its done cycle, is ignored.
- R11: op_imm equals the immediate captured at start for every descriptor of that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Redirection table write enable |
| tbl_addr | input | 5 | Entry written |
| tbl_active | input | 1 | Entry replaces its register number |
| tbl_vec | input | 1 | Entry marks its register as a vector |
| tbl_target | input | 5 | Replacement register number |
| start | input | 1 | One-cycle start pulse (sampled when idle) |
| start_vl | input | 4 | Vector length, 0 to 8 (larger values saturate) |
| start_rs | input | 5 | Source (base address) register number |
| start_rd | input | 5 | Destination register number |
| start_imm | input | 12 | Immediate offset forwarded with each descriptor |
| start_smask | input | 8 | Source predicate mask, bit n = lane n |
| start_dmask | input | 8 | Destination predicate mask, bit n = lane n |
| start_shared | input | 1 | 1 = source mask gates both sides |
| op_valid | output | 1 | Descriptor present |
| op_ready | input | 1 | Consumer accepts the descriptor |
| op_rs | output | 5 | Effective base register of this element |
| op_rd | output | 5 | Effective destination register of this element |
| op_imm | output | 12 | Immediate offset |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
Several properties are checked on every cycle. Stalled descriptors must hold steady, and no descriptor may be valid with an index at or past the vector length. Each index may step by no more than one lane per clock, and a scalar source index must stay frozen. Done must last a single cycle, a zero length must produce done at once, and the both-scalar case must finish after its one issue. Other behaviour only the directed scenarios can show: that the right lanes are chosen for given mask pairs, that redirection and the modulo-32 register arithmetic are correct, that shared-mask mode stops after one issue when the destination is scalar, that lengths saturate, and that a start arriving mid-walk leaves the descriptor stream unchanged.

// File: rtl/seq_pkg.sv
// Shared constants and types for the element index sequencer.
// Assumes a 32-entry integer register space addressed by 5 bits.
package seq_pkg;
    localparam int REG_W    = 5;
    localparam int NUM_REGS = 1 << REG_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             active;
        logic             is_vec;
        logic [REG_W-1:0] target;
    } redir_entry_t;
endpackage

// File: rtl/seq_redirect_table.sv
// Per-register redirection table with one write port and NPORTS
// combinational lookup ports. A lookup returns the stored target when the
// entry is active and the register number itself otherwise, plus a vector
// flag that is only set for active entries marked as vectors.
// Assumes: reads in the cycle of a write return the old contents.
module seq_redirect_table
    import seq_pkg::*;
#(
    parameter int NPORTS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [REG_W-1:0]              wr_addr,
    input  redir_entry_t                  wr_entry,
    input  logic [NPORTS-1:0][REG_W-1:0]  lk_reg,
    output logic [NPORTS-1:0][REG_W-1:0]  lk_eff,
    output logic [NPORTS-1:0]             lk_vec
);
    redir_entry_t tab_q [NUM_REGS];

    // Table storage: cleared on reset, one entry written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                tab_q[k] <= '0;
            end
        end else if (wr_en) begin
            tab_q[wr_addr] <= wr_entry;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_lookup
        redir_entry_t hit;
        // Lookup port p: substitute the target when the entry is active.
        always_comb begin
            hit       = tab_q[lk_reg[p]];
            lk_eff[p] = hit.active ? hit.target : lk_reg[p];
            lk_vec[p] = hit.active & hit.is_vec;
        end
    end
endmodule

// File: rtl/seq_lane_walker.sv
// Walks the source and destination element indices of one vectorised
// access and emits one descriptor per element on a valid/ready handshake.
// Dual mode: i skips clear source-mask lanes, j skips clear destination-
// mask lanes, and each side advances only if it is a vector. Shared mode:
// i is the only lane index, gated by the source mask. At most one lane is
// skipped per index per clock. Assumes register numbers have already been
// redirected and start is only honoured in the idle state.
module seq_lane_walker
    import seq_pkg::*;
#(
    parameter  int LANES = 8,
    parameter  int IMM_W = 12,
    localparam int IDX_W = $clog2(LANES + 1),
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] vl_in,
    input  logic [REG_W-1:0] rs_eff,
    input  logic [REG_W-1:0] rd_eff,
    input  logic             src_vec,
    input  logic             dst_vec,
    input  logic             shared,
    input  logic [IMM_W-1:0] imm,
    input  logic [LANES-1:0] smask,
    input  logic [LANES-1:0] dmask,
    output logic             op_valid,
    input  logic             op_ready,
    output logic [REG_W-1:0] op_rs,
    output logic [REG_W-1:0] op_rd,
    output logic [IMM_W-1:0] op_imm,
    output logic             done
);
    seq_state_e       state_q;
    logic [IDX_W-1:0] i_q, j_q, vl_q;
    logic [LANES-1:0] smask_q, dmask_q;
    logic             svec_q, dvec_q, shared_q;
    logic [REG_W-1:0] rs_q, rd_q;
    logic [IMM_W-1:0] imm_q;

    logic             end_now, skip_i, skip_j, issue, fire, last_op;
    logic [IDX_W-1:0] vl_clamped, dst_idx;

    // Saturate the requested length to the lane count.
    always_comb begin
        vl_clamped = (vl_in > IDX_W'(LANES)) ? IDX_W'(LANES) : vl_in;
    end

    // Per-cycle decision: end of walk, lane skips, or issue.
    always_comb begin
        end_now = (i_q >= vl_q) || (!shared_q && (j_q >= vl_q));
        skip_i  = (state_q == ST_RUN) && !end_now && (shared_q || svec_q)
                  && !smask_q[i_q[SEL_W-1:0]];
        skip_j  = (state_q == ST_RUN) && !end_now && !shared_q && dvec_q
                  && !dmask_q[j_q[SEL_W-1:0]];
        issue   = (state_q == ST_RUN) && !end_now && !skip_i && !skip_j;
        fire    = issue && op_ready;
        last_op = shared_q ? !dvec_q : (!svec_q && !dvec_q);
    end

    // Descriptor outputs formed from the captured bases and live indices.
    always_comb begin
        dst_idx  = shared_q ? i_q : j_q;
        op_valid = issue;
        op_rs    = rs_q + (svec_q ? REG_W'(i_q) : '0);
        op_rd    = rd_q + (dvec_q ? REG_W'(dst_idx) : '0);
        op_imm   = imm_q;
        done     = (state_q == ST_FIN);
    end

    // Sequencing state: capture on start, then walk until the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            i_q      <= '0;
            j_q      <= '0;
            vl_q     <= '0;
            smask_q  <= '0;
            dmask_q  <= '0;
            svec_q   <= 1'b0;
            dvec_q   <= 1'b0;
            shared_q <= 1'b0;
            rs_q     <= '0;
            rd_q     <= '0;
            imm_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        i_q      <= '0;
                        j_q      <= '0;
                        vl_q     <= vl_clamped;
                        smask_q  <= smask;
                        dmask_q  <= dmask;
                        svec_q   <= src_vec;
                        dvec_q   <= dst_vec;
                        shared_q <= shared;
                        rs_q     <= rs_eff;
                        rd_q     <= rd_eff;
                        imm_q    <= imm;
                        state_q  <= (vl_clamped == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (skip_i || (fire && (shared_q || svec_q))) begin
                        i_q <= i_q + 1'b1;
                    end
                    if (skip_j || (fire && !shared_q && dvec_q)) begin
                        j_q <= j_q + 1'b1;
                    end
                    if (end_now || (fire && last_op)) begin
                        state_q <= ST_FIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8: a stalled descriptor stays valid and unchanged.
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready) |=> (op_valid && $stable(op_rs)
                                     && $stable(op_rd) && $stable(op_imm)));

    // R4: nothing is issued at or beyond the vector length.
    a_r4_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> ((i_q < vl_q) && (shared_q || (j_q < vl_q))));

    // R4: done lasts exactly one cycle.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: each index steps by at most one lane per clock while walking.
    a_r9_i_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> ((i_q == $past(i_q)) || (i_q == $past(i_q) + 1'b1)));
    a_r9_j_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> ((j_q == $past(j_q)) || (j_q == $past(j_q) + 1'b1)));

    // R3: a scalar source in dual mode never moves its index.
    a_r3_scalar_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && !svec_q && !shared_q) |=> $stable(i_q));

    // R5: both-scalar dual walk finishes right after its single issue.
    a_r5_single_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !shared_q && !svec_q && !dvec_q) |=> done);

    // R6: shared mode with a scalar destination finishes after its first issue.
    a_r6_shared_scalar_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && shared_q && !dvec_q) |=> done);

    // R7: a zero-length start yields done in the next cycle.
    a_r7_zero_len_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && start && (vl_in == '0)) |=> done);
endmodule

// File: rtl/elem_seq_top.sv
// Top of the dual-predicated element index sequencer. Redirects the source
// and destination register numbers through the table at start and hands
// the result to the lane walker, which issues one descriptor per element.
// Assumes start is a single-cycle pulse; starts during a walk are dropped.
module elem_seq_top
    import seq_pkg::*;
#(
    parameter  int LANES = 8,
    parameter  int IMM_W = 12,
    localparam int IDX_W = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_we,
    input  logic [REG_W-1:0] tbl_addr,
    input  logic             tbl_active,
    input  logic             tbl_vec,
    input  logic [REG_W-1:0] tbl_target,
    input  logic             start,
    input  logic [IDX_W-1:0] start_vl,
    input  logic [REG_W-1:0] start_rs,
    input  logic [REG_W-1:0] start_rd,
    input  logic [IMM_W-1:0] start_imm,
    input  logic [LANES-1:0] start_smask,
    input  logic [LANES-1:0] start_dmask,
    input  logic             start_shared,
    output logic             op_valid,
    input  logic             op_ready,
    output logic [REG_W-1:0] op_rs,
    output logic [REG_W-1:0] op_rd,
    output logic [IMM_W-1:0] op_imm,
    output logic             done
);
    localparam int P_SRC = 0;
    localparam int P_DST = 1;

    redir_entry_t                wr_entry;
    logic [1:0][REG_W-1:0]       lk_reg;
    logic [1:0][REG_W-1:0]       lk_eff;
    logic [1:0]                  lk_vec;

    // Pack the table write and the two lookups.
    always_comb begin
        wr_entry.active = tbl_active;
        wr_entry.is_vec = tbl_vec;
        wr_entry.target = tbl_target;
        lk_reg[P_SRC]   = start_rs;
        lk_reg[P_DST]   = start_rd;
    end

    seq_redirect_table #(
        .NPORTS (2)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_addr  (tbl_addr),
        .wr_entry (wr_entry),
        .lk_reg   (lk_reg),
        .lk_eff   (lk_eff),
        .lk_vec   (lk_vec)
    );

    seq_lane_walker #(
        .LANES (LANES),
        .IMM_W (IMM_W)
    ) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .vl_in    (start_vl),
        .rs_eff   (lk_eff[P_SRC]),
        .rd_eff   (lk_eff[P_DST]),
        .src_vec  (lk_vec[P_SRC]),
        .dst_vec  (lk_vec[P_DST]),
        .shared   (start_shared),
        .imm      (start_imm),
        .smask    (start_smask),
        .dmask    (start_dmask),
        .op_valid (op_valid),
        .op_ready (op_ready),
        .op_rs    (op_rs),
        .op_rd    (op_rd),
        .op_imm   (op_imm),
        .done     (done)
    );
endmodule

// File: tb/elem_seq_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each comparing the descriptor
// stream against a model built from the requirements.
module elem_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [4:0]  tbl_addr = '0;
    logic        tbl_active = 1'b0;
    logic        tbl_vec = 1'b0;
    logic [4:0]  tbl_target = '0;
    logic        start = 1'b0;
    logic [3:0]  start_vl = '0;
    logic [4:0]  start_rs = '0;
    logic [4:0]  start_rd = '0;
    logic [11:0] start_imm = '0;
    logic [7:0]  start_smask = '0;
    logic [7:0]  start_dmask = '0;
    logic        start_shared = 1'b0;
    logic        op_valid;
    logic        op_ready = 1'b1;
    logic [4:0]  op_rs;
    logic [4:0]  op_rd;
    logic [11:0] op_imm;
    logic        done;

    always #2.5 clk = ~clk;

    elem_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_active(tbl_active), .tbl_vec(tbl_vec), .tbl_target(tbl_target),
        .start(start), .start_vl(start_vl), .start_rs(start_rs),
        .start_rd(start_rd), .start_imm(start_imm), .start_smask(start_smask),
        .start_dmask(start_dmask), .start_shared(start_shared),
        .op_valid(op_valid), .op_ready(op_ready), .op_rs(op_rs),
        .op_rd(op_rd), .op_imm(op_imm), .done(done)
    );

    int n_checks = 0;
    int n_fail = 0;

    bit       sh_act [32];
    bit       sh_vec [32];
    int       sh_tgt [32];
    int       exp_rs [16];
    int       exp_rd [16];
    int       exp_n;
    int       got_rs [32];
    int       got_rd [32];
    int       got_imm [32];
    int       got_n;
    int       first_cyc;
    int       done_cyc;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tbl_write(input int addr, input bit act, input bit vec, input int tgt);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = addr[4:0]; tbl_active = act;
        tbl_vec = vec; tbl_target = tgt[4:0];
        @(negedge clk);
        tbl_we = 1'b0;
        sh_act[addr] = act; sh_vec[addr] = vec; sh_tgt[addr] = tgt;
    endtask

    // Reference walk derived from R1-style redirection and the lane rules.
    task automatic build_expect(input int vl, input int rs, input int rd,
                                input int sm, input int dm, input bit sh);
        int  vlc  = (vl > 8) ? 8 : vl;
        int  rse  = sh_act[rs] ? sh_tgt[rs] : rs;
        int  rde  = sh_act[rd] ? sh_tgt[rd] : rd;
        bit  sv   = sh_act[rs] && sh_vec[rs];
        bit  dv   = sh_act[rd] && sh_vec[rd];
        int  i = 0;
        int  j = 0;
        exp_n = 0;
        if (sh) begin
            while (i < vlc) begin
                if (((sm >> i) & 1) == 0) begin i++; continue; end
                exp_rs[exp_n] = (rse + (sv ? i : 0)) % 32;
                exp_rd[exp_n] = (rde + (dv ? i : 0)) % 32;
                exp_n++;
                if (!dv) break;
                i++;
            end
        end else begin
            while (i < vlc && j < vlc) begin
                if (sv && (((sm >> i) & 1) == 0)) begin i++; continue; end
                if (dv && (((dm >> j) & 1) == 0)) begin j++; continue; end
                exp_rs[exp_n] = (rse + i) % 32;
                exp_rd[exp_n] = (rde + j) % 32;
                exp_n++;
                if (!sv && !dv) break;
                if (sv) i++;
                if (dv) j++;
            end
        end
    endtask

    task automatic run(input string req, input int vl, input int rs, input int rd,
                       input int sm, input int dm, input bit sh, input bit stall,
                       input bit inject, input int exp_first, input int exp_done);
        int  imm = 12'h100 + rs * 7 + vl;
        bit  held = 1'b0;
        int  h_rs = 0, h_rd = 0, h_imm = 0;
        build_expect(vl, rs, rd, sm, dm, sh);
        got_n = 0; first_cyc = -1; done_cyc = -1;
        @(negedge clk);
        start = 1'b1; start_vl = vl[3:0]; start_rs = rs[4:0]; start_rd = rd[4:0];
        start_imm = imm[11:0]; start_smask = sm[7:0]; start_dmask = dm[7:0];
        start_shared = sh;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c < 300; c++) begin
            op_ready = stall ? ((c % 3) != 0) : 1'b1;
            if (inject && c == 3) begin
                start = 1'b1; start_vl = 4'd2; start_rs = 5'd6; start_rd = 5'd4;
                start_imm = 12'hABC; start_shared = 1'b1;
            end else begin
                start = 1'b0;
            end
            #1;
            if (held) begin
                check(op_valid && op_rs == h_rs[4:0] && op_rd == h_rd[4:0]
                      && op_imm == h_imm[11:0], "R8", "stalled descriptor held",
                      {op_valid, op_rs}, {1'b1, h_rs[4:0]});
            end
            held = op_valid && !op_ready;
            h_rs = op_rs; h_rd = op_rd; h_imm = op_imm;
            if (op_valid && op_ready && got_n < 32) begin
                if (first_cyc < 0) first_cyc = c;
                got_rs[got_n] = op_rs; got_rd[got_n] = op_rd; got_imm[got_n] = op_imm;
                got_n++;
            end
            if (done) begin done_cyc = c; break; end
            @(negedge clk);
        end
        op_ready = 1'b1; start = 1'b0;
        check(done_cyc > 0, "R4", "done reached", done_cyc, 1);
        check(got_n == exp_n, req, "descriptor count", got_n, exp_n);
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            check(got_rs[k] == exp_rs[k], req, "op_rs", got_rs[k], exp_rs[k]);
            check(got_rd[k] == exp_rd[k], req, "op_rd", got_rd[k], exp_rd[k]);
            check(got_imm[k] == imm, "R11", "op_imm", got_imm[k], imm);
        end
        if (exp_first >= 0) check(first_cyc == exp_first, "R9", "first issue cycle", first_cyc, exp_first);
        if (exp_done >= 0) check(done_cyc == exp_done, "R7", "done cycle", done_cyc, exp_done);
    endtask

    task automatic t_reset();
        #1;
        check(!op_valid, "R4", "op_valid after reset", op_valid, 0);
        check(!done, "R4", "done after reset", done, 0);
    endtask

    task automatic t_redirect();
        run("R1", 4, 1, 3, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, -1, -1);
        run("R1", 4, 4, 6, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, -1, -1);
    endtask

    task automatic t_dual_masks();
        run("R2", 8, 1, 2, 8'b1011_0101, 8'b0110_1110, 1'b0, 1'b0, 1'b0, -1, -1);
        run("R2", 6, 2, 1, 8'b0010_0110, 8'b1111_0001, 1'b0, 1'b0, 1'b0, -1, -1);
    endtask

    task automatic t_wrap();
        run("R3", 4, 5, 2, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, -1, -1);
    endtask

    task automatic t_both_scalar();
        run("R5", 8, 6, 4, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, -1, -1);
    endtask

    task automatic t_shared();
        run("R6", 7, 1, 2, 8'b0101_0010, 8'h00, 1'b1, 1'b0, 1'b0, -1, -1);
        run("R6", 8, 1, 3, 8'b0011_0000, 8'h00, 1'b1, 1'b0, 1'b0, -1, -1);
    endtask

    task automatic t_lengths();
        run("R7", 0, 1, 2, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, -1, 1);
        run("R7", 15, 1, 4, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, -1, -1);
    endtask

    task automatic t_skip_off_end();
        run("R4", 8, 1, 2, 8'b0000_0011, 8'hFF, 1'b0, 1'b0, 1'b0, -1, -1);
        run("R4", 8, 1, 2, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, -1, -1);
    endtask

    task automatic t_stall();
        run("R8", 8, 1, 2, 8'b1011_0101, 8'b0110_1110, 1'b0, 1'b1, 1'b0, -1, -1);
    endtask

    task automatic t_skip_rate();
        run("R9", 8, 1, 3, 8'h80, 8'h00, 1'b0, 1'b0, 1'b0, 8, -1);
    endtask

    task automatic t_restart_ignored();
        run("R10", 5, 1, 2, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, -1, -1);
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 32; k++) begin
            sh_act[k] = 1'b0; sh_vec[k] = 1'b0; sh_tgt[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        tbl_write(1, 1'b1, 1'b1, 8);
        tbl_write(2, 1'b1, 1'b1, 16);
        tbl_write(3, 1'b1, 1'b0, 20);
        tbl_write(5, 1'b1, 1'b1, 30);
        tbl_write(4, 1'b0, 1'b1, 9);
        t_redirect();
        t_dual_masks();
        t_wrap();
        t_both_scalar();
        t_shared();
        t_lengths();
        t_skip_off_end();
        t_stall();
        t_skip_rate();
        t_restart_ignored();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule